// File: doc/BRIEF.md
# Status Register with Legalizing Writes

This block holds the machine-level status word of a processor hart and offers a restricted supervisor window onto it. Every write is filtered field by field before it lands. Bits that are not writable keep their value. A previous-privilege value naming an absent or reserved mode is dropped while the rest of the write still applies. The floating-point state field is forced to read only as off or dirty. The summary-dirty bit is recomputed from the state fields.

Software reaches the register through a single-cycle access port. The port offers a read, a plain write, a bit-set and a bit-clear, and the read data always shows the value held before the access. A configuration pair tells the block which of the supervisor and user modes exist. The individual interrupt-enable, previous-privilege and translation-control fields drive dedicated outputs.

When a committed write changes any field that affects address translation, a small two-state machine (states `FLUSH_IDLE` and `FLUSH_PULSE`) raises a flush request to the translation cache. The machine takes the transition IDLE→PULSE on a changing write and PULSE→IDLE when no changing write follows. PULSE→PULSE occurs only for back-to-back changing writes.

Top module: `mstat_csr`

## Requirements
- R1: While `rst_n` is low and after it is released, the register holds 0x0000_1800: every field is zero except the previous-privilege field MPP (bits 12:11), which is 2'b11. `flush_o` is low.
- R2: `csr_op` encodes 00 = read (no change), 01 = write, 10 = set (old OR data), 11 = clear (old AND NOT data). The operation applies at the clock edge while `csr_en` is high. `csr_rdata` shows the selected view of the value held before that edge.
- R3: Only these bits are writable: SIE 1, MIE 3, SPIE 5, MPIE 7, SPP 8, MPP 12:11, FS 14:13, MPRV 17, SUM 18 and MXR 19. Every other bit, including UIE 0, UPIE 4 and XS 16:15, keeps its value. SD is an exception and follows R6.
- R4: A write that would set MPP to 2'b10, to 2'b01 while `has_smode` is 0, or to 2'b00 while `has_umode` is 0 leaves MPP unchanged. The other fields of the same write still take effect.
- R5: After any write, a non-zero FS is stored as 2'b11, so FS reads only as 2'b00 or 2'b11.
- R6: SD (bit XLEN-1) is not writable and equals 1 exactly when FS or XS is 2'b11.
- R7: With `csr_sel` = 1 the supervisor view reads the register ANDed with the bits UIE 0, SIE 1, UPIE 4, SPIE 5, SPP 8, FS 14:13, XS 16:15, SUM 18, MXR 19 and SD. A write in this view changes only those bits and then obeys R3 to R6.
- R8: `flush_o` is high for exactly one cycle, the cycle after a write whose stored result differs from the old value in MXR, MPP, MPRV or SUM. It stays low after writes that leave those fields unchanged, including a rejected MPP value.
- R9: The field outputs `sie_o`, `mie_o`, `spie_o`, `mpie_o`, `spp_o`, `mpp_o`, `fs_o`, `mprv_o`, `sum_o` and `mxr_o` show the stored fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| has_smode | input | 1 | Supervisor mode is implemented |
| has_umode | input | 1 | User mode is implemented |
| csr_en | input | 1 | Access strobe |
| csr_sel | input | 1 | 0 = machine view, 1 = supervisor view |
| csr_op | input | 2 | Access operation (R2) |
| csr_wdata | input | XLEN | Write, set or clear operand |
| csr_rdata | output | XLEN | Selected view of the current value |
| sie_o | output | 1 | Supervisor interrupt enable |
| mie_o | output | 1 | Machine interrupt enable |
| spie_o | output | 1 | Supervisor previous interrupt enable |
| mpie_o | output | 1 | Machine previous interrupt enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mpp_o | output | 2 | Machine previous privilege |
| fs_o | output | 2 | Floating-point state |
| mprv_o | output | 1 | Modify-privilege for loads and stores |
| sum_o | output | 1 | Supervisor access to user memory |
| mxr_o | output | 1 | Make executable readable |
| flush_o | output | 1 | One-cycle translation-cache flush request |

## Verification
The assertions assume that `has_smode` and `has_umode` are never both changed in a way that makes an already stored MPP illegal. They check the stored value only for encodings that no write can produce, never for one that depends on the current configuration. They also take `csr_op` to be stable across the cycle in which `csr_en` is high. The stimulus changes the mode configuration only together with a write and drives every access input at the falling edge, so both conditions hold throughout.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    typedef enum logic [1:0] {
        CSR_READ  = 2'b00,
        CSR_WRITE = 2'b01,
        CSR_SET   = 2'b10,
        CSR_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic {
        FLUSH_IDLE  = 1'b0,
        FLUSH_PULSE = 1'b1
    } flush_state_e;

    localparam int POS_UIE  = 0;
    localparam int POS_SIE  = 1;
    localparam int POS_MIE  = 3;
    localparam int POS_UPIE = 4;
    localparam int POS_SPIE = 5;
    localparam int POS_MPIE = 7;
    localparam int POS_SPP  = 8;
    localparam int POS_MPP  = 11;
    localparam int POS_FS   = 13;
    localparam int POS_XS   = 15;
    localparam int POS_MPRV = 17;
    localparam int POS_SUM  = 18;
    localparam int POS_MXR  = 19;

    localparam logic [1:0] PRIV_USER  = 2'b00;
    localparam logic [1:0] PRIV_SUPER = 2'b01;
    localparam logic [1:0] PRIV_RSVD  = 2'b10;
    localparam logic [1:0] PRIV_MACH  = 2'b11;

endpackage

// File: rtl/mstat_view.sv
module mstat_view
    import mstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            view_sup,
    input  csr_op_e         op,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] cur,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] proposed
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);
    localparam logic [XLEN-1:0] SUP_MASK =
        (ONE << POS_UIE)  | (ONE << POS_SIE)  | (ONE << POS_UPIE) |
        (ONE << POS_SPIE) | (ONE << POS_SPP)  | (ONE << POS_FS)   |
        (ONE << (POS_FS + 1)) | (ONE << POS_XS) | (ONE << (POS_XS + 1)) |
        (ONE << POS_SUM)  | (ONE << POS_MXR)  | (ONE << (XLEN - 1));

    logic [XLEN-1:0] vmask;
    logic [XLEN-1:0] vnew;

    always_comb begin
        vmask = view_sup ? SUP_MASK : '1;
        rdata = cur & vmask;
        unique case (op)
            CSR_WRITE: vnew = wdata;
            CSR_SET:   vnew = rdata | wdata;
            CSR_CLEAR: vnew = rdata & ~wdata;
            default:   vnew = rdata;
        endcase
        proposed = (cur & ~vmask) | (vnew & vmask);
    end
endmodule

// File: rtl/mstat_legalize.sv
module mstat_legalize
    import mstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            has_smode,
    input  logic            has_umode,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] proposed,
    output logic [XLEN-1:0] next_val,
    output logic            xlat_changed
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);
    localparam logic [XLEN-1:0] MPP_BITS = (ONE << POS_MPP) | (ONE << (POS_MPP + 1));
    localparam logic [XLEN-1:0] BASE_MASK =
        (ONE << POS_SIE)  | (ONE << POS_MIE)  | (ONE << POS_SPIE) |
        (ONE << POS_MPIE) | (ONE << POS_SPP)  | MPP_BITS |
        (ONE << POS_FS)   | (ONE << (POS_FS + 1)) |
        (ONE << POS_MPRV) | (ONE << POS_SUM)  | (ONE << POS_MXR);
    localparam logic [XLEN-1:0] XLAT_BITS =
        (ONE << POS_MXR) | (ONE << POS_MPRV) | (ONE << POS_SUM) | MPP_BITS;

    logic [1:0]      new_mpp;
    logic            mpp_bad;
    logic [XLEN-1:0] wmask;
    logic [XLEN-1:0] merged;

    always_comb begin
        new_mpp = proposed[POS_MPP +: 2];
        mpp_bad = (new_mpp == PRIV_RSVD) ||
                  (new_mpp == PRIV_SUPER && !has_smode) ||
                  (new_mpp == PRIV_USER  && !has_umode);
        wmask   = mpp_bad ? (BASE_MASK & ~MPP_BITS) : BASE_MASK;
        merged  = (old_val & ~wmask) | (proposed & wmask);
        if (merged[POS_FS +: 2] != 2'b00) begin
            merged[POS_FS +: 2] = 2'b11;
        end
        merged[XLEN-1] = (merged[POS_FS +: 2] == 2'b11) ||
                         (merged[POS_XS +: 2] == 2'b11);
        next_val     = merged;
        xlat_changed = ((merged ^ old_val) & XLAT_BITS) != '0;
    end
endmodule

// File: rtl/mstat_flush_fsm.sv
module mstat_flush_fsm
    import mstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic flush_o
);
    flush_state_e state_q;
    flush_state_e state_d;

    always_comb begin
        unique case (state_q)
            FLUSH_IDLE:  state_d = trigger ? FLUSH_PULSE : FLUSH_IDLE;
            FLUSH_PULSE: state_d = trigger ? FLUSH_PULSE : FLUSH_IDLE;
            default:     state_d = FLUSH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLUSH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flush_o = (state_q == FLUSH_PULSE);
    end

    assert_pulse_follows_trigger_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!trigger) |=> !flush_o
    );
endmodule

// File: rtl/mstat_csr.sv
module mstat_csr
    import mstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            has_smode,
    input  logic            has_umode,
    input  logic            csr_en,
    input  logic            csr_sel,
    input  logic [1:0]      csr_op,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            sie_o,
    output logic            mie_o,
    output logic            spie_o,
    output logic            mpie_o,
    output logic            spp_o,
    output logic [1:0]      mpp_o,
    output logic [1:0]      fs_o,
    output logic            mprv_o,
    output logic            sum_o,
    output logic            mxr_o,
    output logic            flush_o
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);
    localparam logic [XLEN-1:0] RESET_VAL = XLEN'(PRIV_MACH) << POS_MPP;
    localparam logic [XLEN-1:0] OPEN_BITS =
        (ONE << POS_SIE)  | (ONE << POS_MIE)  | (ONE << POS_SPIE) |
        (ONE << POS_MPIE) | (ONE << POS_SPP)  | (ONE << POS_MPP) |
        (ONE << (POS_MPP + 1)) | (ONE << POS_FS) | (ONE << (POS_FS + 1)) |
        (ONE << POS_MPRV) | (ONE << POS_SUM)  | (ONE << POS_MXR) |
        (ONE << (XLEN - 1));
    localparam logic [XLEN-1:0] XLAT_BITS =
        (ONE << POS_MXR) | (ONE << POS_MPRV) | (ONE << POS_SUM) |
        (ONE << POS_MPP) | (ONE << (POS_MPP + 1));

    csr_op_e         op_e;
    logic [XLEN-1:0] status_q;
    logic [XLEN-1:0] proposed;
    logic [XLEN-1:0] legal_val;
    logic            xlat_changed;
    logic            do_write;

    assign op_e     = csr_op_e'(csr_op);
    assign do_write = csr_en && (op_e != CSR_READ);

    mstat_view #(.XLEN(XLEN)) u_view (
        .view_sup (csr_sel),
        .op       (op_e),
        .wdata    (csr_wdata),
        .cur      (status_q),
        .rdata    (csr_rdata),
        .proposed (proposed)
    );

    mstat_legalize #(.XLEN(XLEN)) u_legal (
        .has_smode    (has_smode),
        .has_umode    (has_umode),
        .old_val      (status_q),
        .proposed     (proposed),
        .next_val     (legal_val),
        .xlat_changed (xlat_changed)
    );

    mstat_flush_fsm u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (do_write && xlat_changed),
        .flush_o (flush_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= RESET_VAL;
        end else if (do_write) begin
            status_q <= legal_val;
        end
    end

    always_comb begin
        sie_o  = status_q[POS_SIE];
        mie_o  = status_q[POS_MIE];
        spie_o = status_q[POS_SPIE];
        mpie_o = status_q[POS_MPIE];
        spp_o  = status_q[POS_SPP];
        mpp_o  = status_q[POS_MPP +: 2];
        fs_o   = status_q[POS_FS +: 2];
        mprv_o = status_q[POS_MPRV];
        sum_o  = status_q[POS_SUM];
        mxr_o  = status_q[POS_MXR];
    end

    assert_read_no_change_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (csr_en && op_e == CSR_READ) |=> $stable(status_q)
    );

    assert_locked_bits_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~OPEN_BITS) == ($past(status_q) & ~OPEN_BITS))
    );

    assert_mpp_never_reserved_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        status_q[POS_MPP +: 2] != PRIV_RSVD
    );

    assert_fs_off_or_dirty_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        status_q[POS_FS +: 2] == 2'b00 || status_q[POS_FS +: 2] == 2'b11
    );

    assert_sd_summary_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        status_q[XLEN-1] == ((status_q[POS_FS +: 2] == 2'b11) ||
                             (status_q[POS_XS +: 2] == 2'b11))
    );

    assert_flush_has_cause_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        flush_o |-> ((status_q & XLAT_BITS) != ($past(status_q) & XLAT_BITS))
    );
endmodule

// File: tb/mstat_csr_test.sv
module mstat_csr_test;
    localparam int XLEN = 32;

    typedef struct packed {
        logic        sel;
        logic [1:0]  op;
        logic        hs;
        logic        hu;
        logic [31:0] wd;
        logic [31:0] exp_val;
        logic        exp_fl;
    } vec_t;

    localparam logic [1:0] OP_R = 2'b00;
    localparam logic [1:0] OP_W = 2'b01;
    localparam logic [1:0] OP_S = 2'b10;
    localparam logic [1:0] OP_C = 2'b11;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, OP_W, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h800E_79AA, 1'b1},
        '{1'b0, OP_C, 1'b1, 1'b1, 32'h0000_6000, 32'h000E_19AA, 1'b0},
        '{1'b0, OP_W, 1'b1, 1'b1, 32'h0000_3000, 32'h8000_7800, 1'b1},
        '{1'b0, OP_W, 1'b0, 1'b1, 32'h0000_0800, 32'h0000_1800, 1'b0},
        '{1'b0, OP_W, 1'b1, 1'b1, 32'h0000_0800, 32'h0000_0800, 1'b1},
        '{1'b0, OP_W, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0800, 1'b0},
        '{1'b0, OP_W, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b1},
        '{1'b1, OP_W, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h800C_6122, 1'b1},
        '{1'b1, OP_R, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h800C_6122, 1'b0},
        '{1'b0, OP_S, 1'b1, 1'b1, 32'h0000_0088, 32'h800C_61AA, 1'b0},
        '{1'b1, OP_C, 1'b1, 1'b1, 32'h000C_0000, 32'h8000_61AA, 1'b1},
        '{1'b0, OP_W, 1'b1, 1'b1, 32'h0000_61AA, 32'h8000_61AA, 1'b0},
        '{1'b0, OP_W, 1'b1, 1'b1, 32'h0002_61AA, 32'h8002_61AA, 1'b1}
    };

    logic            clk;
    logic            rst_n;
    logic            has_smode;
    logic            has_umode;
    logic            csr_en;
    logic            csr_sel;
    logic [1:0]      csr_op;
    logic [XLEN-1:0] csr_wdata;
    logic [XLEN-1:0] csr_rdata;
    logic            sie_o, mie_o, spie_o, mpie_o, spp_o;
    logic [1:0]      mpp_o, fs_o;
    logic            mprv_o, sum_o, mxr_o, flush_o;

    int tests_run = 0;
    int tests_failed = 0;

    mstat_csr #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .has_smode(has_smode), .has_umode(has_umode),
        .csr_en(csr_en), .csr_sel(csr_sel), .csr_op(csr_op),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .sie_o(sie_o), .mie_o(mie_o), .spie_o(spie_o), .mpie_o(mpie_o),
        .spp_o(spp_o), .mpp_o(mpp_o), .fs_o(fs_o), .mprv_o(mprv_o),
        .sum_o(sum_o), .mxr_o(mxr_o), .flush_o(flush_o)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    task automatic check(input string what, input logic [31:0] actual,
                         input logic [31:0] expected);
        tests_run++;
        if (actual !== expected) begin
            tests_failed++;
            $display("FAIL %s: actual %h expected %h", what, actual, expected);
        end
    endtask

    task automatic access(input vec_t v);
        @(negedge clk);
        csr_sel   = v.sel;
        csr_op    = v.op;
        csr_wdata = v.wd;
        has_smode = v.hs;
        has_umode = v.hu;
        csr_en    = 1'b1;
        @(negedge clk);
        csr_en  = 1'b0;
        csr_sel = 1'b0;
        csr_op  = OP_R;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        rst_n = 1'b0; has_smode = 1'b1; has_umode = 1'b1;
        csr_en = 1'b0; csr_sel = 1'b0; csr_op = OP_R; csr_wdata = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 value in reset", csr_rdata, 32'h0000_1800);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 value after reset", csr_rdata, 32'h0000_1800);
        check("R1 flush low after reset", {31'b0, flush_o}, 32'h0);
        check("R1 mpp_o after reset", {30'b0, mpp_o}, 32'h3);

        // R2 R3 R4 R5 R6 R7 R8: table walk (machine view checked after each access)
        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i]);
            check($sformatf("R2-R7 vector %0d status", i), csr_rdata, VECS[i].exp_val);
            check($sformatf("R8 vector %0d flush", i), {31'b0, flush_o},
                  {31'b0, VECS[i].exp_fl});
        end

        // R9 field outputs for stored 0x8002_61AA
        check("R9 sie_o",  {31'b0, sie_o},  32'h1);
        check("R9 mie_o",  {31'b0, mie_o},  32'h1);
        check("R9 spie_o", {31'b0, spie_o}, 32'h1);
        check("R9 mpie_o", {31'b0, mpie_o}, 32'h1);
        check("R9 spp_o",  {31'b0, spp_o},  32'h1);
        check("R9 mpp_o",  {30'b0, mpp_o},  32'h0);
        check("R9 fs_o",   {30'b0, fs_o},   32'h3);
        check("R9 mprv_o", {31'b0, mprv_o}, 32'h1);
        check("R9 sum_o",  {31'b0, sum_o},  32'h0);
        check("R9 mxr_o",  {31'b0, mxr_o},  32'h0);

        // R7 supervisor read view hides MIE, MPIE, MPRV
        @(negedge clk);
        csr_sel = 1'b1;
        #1;
        check("R7 supervisor view read", csr_rdata, 32'h8000_6122);

        // R2 read data is the pre-write value during a write
        @(negedge clk);
        csr_sel = 1'b0; csr_op = OP_W; csr_wdata = '0; csr_en = 1'b1;
        #1;
        check("R2 rdata before edge", csr_rdata, 32'h8002_61AA);
        @(negedge clk);
        csr_en = 1'b0; csr_op = OP_R;
        #1;
        check("R2 write of zero result", csr_rdata, 32'h0000_0000);
        check("R8 flush on changing write", {31'b0, flush_o}, 32'h1);
        @(negedge clk);
        #1;
        check("R8 flush lasts one cycle", {31'b0, flush_o}, 32'h0);

        // R1 reset mid-run restores the reset value
        rst_n = 1'b0;
        #1;
        check("R1 asynchronous reset value", csr_rdata, 32'h0000_1800);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 flush low after second reset", {31'b0, flush_o}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule